// File: doc/BRIEF.md
# Compare-and-Select Branch Target Unit

This block gives a machine whose only instruction is a move a way to branch on a condition. It is a small bus slave that holds four words: two candidate jump targets and two values to compare. Software loads the targets and the values with ordinary writes. It then reads the select register and moves the word it gets into the program counter. That word is the first target when the two values are equal and the second target when they differ.

The compare is a full-width equality test. The selected target comes from the stored registers through combinational logic, so a read in the cycle right after a write already sees the new contents. The other three offsets read back what was stored. Read data is zero unless the unit is selected and read-strobed. Decoding the unit's base address in the system map is done outside this block.

Top module: `cas_branch_unit`

## Requirements
- R1: After a synchronous active-low reset all four registers hold zero: offsets 1, 2 and 3 read 0, and offset 0 reads 0 (the two values are equal, so the first target is selected).
- R2: A write with `sel`=1 and `wr_en`=1 at the next rising clock edge loads `wdata` into the register chosen by `offset`: 0 = first target (taken on equal), 1 = second target (taken on not equal), 2 = compare value B, 3 = compare value A. The other three registers keep their contents.
- R3: A cycle with `sel`=0 or `wr_en`=0 changes no register, whatever `offset` and `wdata` are.
- R4: A read at offset 0 returns the first target when compare value A equals compare value B over all DATA_W bits.
- R5: A read at offset 0 returns the second target when A and B differ, including when they differ in one bit only.
- R6: Reads at offset 1, 2 and 3 return the stored second target, compare value B and compare value A.
- R7: `rdata` is 0 in every cycle where `sel` and `rd_en` are not both 1.
- R8: The read path is combinational. A read in the cycle after a write to a compare value or a target already returns the result based on the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Unit selected by the external address decode |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| offset | input | 2 | Register offset within the unit |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data, zero unless a read is in progress |

## Verification
The hardest case to reach is two compare values that differ in exactly one bit, or that match by chance. With uniform random 16-bit words, a match almost never happens and a one-bit difference is very rare. The stimulus therefore draws compare values mostly from a small pool of four words. It also flips a single random bit of value A against value B, so that both branch outcomes and the nearest miss occur often. Writes without a strobe or without a select are mixed into the same stream. Each one is followed by a read-back, which shows whether it left the registers untouched.

// File: rtl/cas_branch_pkg.sv
// Package: shared constants and offset encoding for the branch target unit.
// Assumes: four registers addressed by a 2-bit offset.
package cas_branch_pkg;
    localparam int NUM_REGS = 4;
    localparam int OFS_W    = $clog2(NUM_REGS);

    // Register offsets; the select logic depends on this assignment.
    typedef enum logic [OFS_W-1:0] {
        OFS_TGT_EQ = 2'd0,
        OFS_TGT_NE = 2'd1,
        OFS_VAL_B  = 2'd2,
        OFS_VAL_A  = 2'd3
    } ofs_e;
endpackage

// File: rtl/cas_branch_regs.sv
// Module: register bank holding the two targets and two compare values.
// Assumes: the caller qualifies wr_go with select and write strobe.
module cas_branch_regs
    import cas_branch_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_go,
    input  logic [OFS_W-1:0]                 wr_ofs,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [OFS_W-1:0] IDX = OFS_W'(i);
        logic hit;

        // Decode: this register is the write target.
        assign hit = wr_go && (wr_ofs == IDX);

        // Storage: clear on reset, load on a decoded write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (hit) begin
                regs_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/cas_branch_select.sv
// Module: equality comparator picking one of two targets.
// Assumes: purely combinational; inputs come straight from registers.
module cas_branch_select #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] tgt_eq,
    input  logic [DATA_W-1:0] tgt_ne,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_b,
    output logic [DATA_W-1:0] tgt_out
);
    logic same;

    // Compare and choose the target.
    always_comb begin
        same    = (val_a == val_b);
        tgt_out = same ? tgt_eq : tgt_ne;
    end
endmodule

// File: rtl/cas_branch_rdmux.sv
// Module: read data multiplexer with zero output when idle.
// Assumes: rd_go already qualified with select and read strobe.
module cas_branch_rdmux
    import cas_branch_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             rd_go,
    input  logic [OFS_W-1:0]                 rd_ofs,
    input  logic [DATA_W-1:0]                sel_tgt,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]                rd_data
);
    // Route the addressed word, or zero when no read is active.
    always_comb begin
        rd_data = '0;
        if (rd_go) begin
            unique case (ofs_e'(rd_ofs))
                OFS_TGT_EQ: rd_data = sel_tgt;
                OFS_TGT_NE: rd_data = regs_q[OFS_TGT_NE];
                OFS_VAL_B:  rd_data = regs_q[OFS_VAL_B];
                OFS_VAL_A:  rd_data = regs_q[OFS_VAL_A];
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cas_branch_unit.sv
// Module: top of the compare-and-select branch target unit.
// Assumes: base address decode happens outside and arrives on sel.
module cas_branch_unit
    import cas_branch_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               sel_tgt;
    logic                            wr_go;
    logic                            rd_go;

    // Qualify the strobes with the select.
    assign wr_go = sel && wr_en;
    assign rd_go = sel && rd_en;

    cas_branch_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_ofs  (offset),
        .wr_data (wdata),
        .regs_q  (regs_q)
    );

    cas_branch_select #(.DATA_W(DATA_W)) u_select (
        .tgt_eq  (regs_q[OFS_TGT_EQ]),
        .tgt_ne  (regs_q[OFS_TGT_NE]),
        .val_a   (regs_q[OFS_VAL_A]),
        .val_b   (regs_q[OFS_VAL_B]),
        .tgt_out (sel_tgt)
    );

    cas_branch_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .rd_go   (rd_go),
        .rd_ofs  (offset),
        .sel_tgt (sel_tgt),
        .regs_q  (regs_q),
        .rd_data (rdata)
    );
endmodule

// File: rtl/cas_branch_unit_chk.sv
// Checker: temporal properties of the branch target unit, bound to the top.
module cas_branch_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        offset,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] tgt_eq,
    input logic [DATA_W-1:0] tgt_ne,
    input logic [DATA_W-1:0] val_b,
    input logic [DATA_W-1:0] val_a
);
    a_r2_load_val_a: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && offset == 2'd3) |=> (val_a == $past(wdata)));

    a_r2_load_tgt_ne: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && offset == 2'd1) |=> (tgt_ne == $past(wdata)));

    a_r3_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=> ($stable(tgt_eq) && $stable(tgt_ne)
                             && $stable(val_a) && $stable(val_b)));

    a_r4_equal_picks_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && offset == 2'd0 && val_a == val_b) |-> (rdata == tgt_eq));

    a_r5_differ_picks_second: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && offset == 2'd0 && val_a != val_b) |-> (rdata == tgt_ne));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en) |-> (rdata == '0));
endmodule

bind cas_branch_unit cas_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .offset (offset),
    .wdata  (wdata),
    .rdata  (rdata),
    .tgt_eq (regs_q[0]),
    .tgt_ne (regs_q[1]),
    .val_b  (regs_q[2]),
    .val_a  (regs_q[3])
);

// File: tb/tb_cas_branch_unit.sv
module tb_cas_branch_unit;
    localparam int DATA_W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [1:0]        offset = 2'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_branch_unit #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .offset(offset), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [DATA_W-1:0] exp_read(input logic [1:0] ofs);
        if (ofs == 2'd0) return (model[3] == model[2]) ? model[0] : model[1];
        return model[ofs];
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle from the falling edge; model follows an effective write.
    task automatic cyc_write(input logic [1:0] ofs, input logic [DATA_W-1:0] d,
                             input bit s, input bit w);
        @(negedge clk);
        sel = s; wr_en = w; rd_en = 1'b0; offset = ofs; wdata = d;
        @(posedge clk);
        if (s && w) model[ofs] = d;
        #1;
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] ofs, input string req);
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1; wr_en = 1'b0; offset = ofs;
        wdata = DATA_W'($urandom);
        #1;
        check(req, rdata, exp_read(ofs));
        @(posedge clk);
        #1;
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rd_all(input string req);
        for (int k = 0; k < 4; k++) rd_check(2'(k), req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] pool [4];
        void'($urandom(32'd1234));
        for (int k = 0; k < 4; k++) model[k] = '0;
        pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h5A5A; pool[3] = 16'h0001;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_all("R1 reset");

        // R7: idle read outputs zero, with registers nonzero
        cyc_write(2'd1, 16'hBEEF, 1, 1);
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b1; offset = 2'd1; #1;
        check("R7 no sel", rdata, '0);
        sel = 1'b1; rd_en = 1'b0; #1;
        check("R7 no rd_en", rdata, '0);
        sel = 1'b0; rd_en = 1'b0;

        // R2/R6: each offset loads only its own register
        cyc_write(2'd0, 16'h1111, 1, 1);
        cyc_write(2'd2, 16'h2222, 1, 1);
        cyc_write(2'd3, 16'h3333, 1, 1);
        rd_all("R2 R6 load and readback");

        // R8 + R4: write A equal to B, read immediately
        cyc_write(2'd3, 16'h2222, 1, 1);
        rd_check(2'd0, "R8 R4 equal after write");
        // R5: one-bit difference
        cyc_write(2'd3, 16'h2223, 1, 1);
        rd_check(2'd0, "R8 R5 one-bit differ");
        cyc_write(2'd3, 16'hA222, 1, 1);
        rd_check(2'd0, "R5 top-bit differ");

        // R3: writes without select or strobe are ignored
        cyc_write(2'd0, 16'hDEAD, 0, 1);
        cyc_write(2'd2, 16'hDEAD, 1, 0);
        cyc_write(2'd3, 16'hDEAD, 0, 0);
        rd_all("R3 ignored write");

        // R1: reset in the middle clears everything
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        for (int k = 0; k < 4; k++) model[k] = '0;
        rd_all("R1 mid reset");

        // Random mix: biased compare values, one-bit flips, ignored writes
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom_range(0, 9);
            logic [1:0] ofs = 2'($urandom_range(0, 3));
            logic [DATA_W-1:0] d = DATA_W'($urandom);
            bit s = 1'b1;
            bit w = 1'b1;
            if (kind < 4 && ofs >= 2) d = pool[$urandom_range(0, 3)];
            else if (kind == 4) begin
                ofs = 2'd3;
                d = model[2] ^ (DATA_W'(1) << $urandom_range(0, DATA_W-1));
            end else if (kind == 5) begin
                ofs = 2'd3; d = model[2];
            end else if (kind == 6) begin
                s = 1'($urandom_range(0, 1)); w = ~s;
            end
            cyc_write(ofs, d, s, w);
            if (kind == 6) rd_check(ofs, "R3 random ignored");
            else if (model[3] == model[2]) rd_check(2'd0, "R4 random equal");
            else rd_check(2'd0, "R5 random differ");
            if (n % 16 == 0) rd_all("R6 random readback");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule